// File: doc/BRIEF.md
# SIMT Warp Divergence and Reconvergence Stack

This block holds the control-flow state of a single warp whose threads share one program counter. It keeps a small stack of entries. Each entry carries the PC at which its threads will rejoin (the join PC), the PC they will run next, and a mask with one bit per thread. The top entry drives the warp: its next PC is the PC to fetch, and its mask selects the threads that execute.

The issue stage reports two kinds of event. The first is the PC that follows a non-branch instruction. The second is a resolved branch, which carries the per-thread taken mask, the target, the fall-through PC and the join PC computed by the compiler. A branch on which every active thread agrees only moves the PC. A branch that splits the active threads parks the current entry at the join PC and pushes one entry for each path. The path with fewer threads is pushed last, so it runs first. When the top entry's next PC reaches its own join PC, that entry is removed, which brings back the wider mask of the entry below. A split that does not fit in the stack leaves the stack unchanged and raises an error flag that stays set until reset.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one entry: `depth_out` is 1, `pc_out` is `RESET_PC`, `mask_out` is all ones, `pc_valid` is 1 and `overflow` is 0. The bottom entry's join PC is all ones.
- R2: `pc_out` and `mask_out` always show the next PC and the mask of the top entry. An `iss_valid` event writes `iss_pc` into the top entry's next PC, and the new value is visible after the following clock edge.
- R3: A branch is divergent when the active threads disagree. That is, `br_taken & mask_out` is neither zero nor equal to `mask_out`. On a divergent branch the top entry's next PC becomes `br_join`, and two entries are pushed, both with join PC `br_join`. The taken entry has next PC `br_target` and mask `br_taken & mask_out`. The other entry has next PC `br_fallthru` and mask `mask_out & ~br_taken`. `depth_out` rises by 2.
- R4: Of the two pushed entries, the one whose mask has fewer set bits goes on top. When both masks have the same number of set bits, the taken entry goes on top.
- R5: A uniform branch pushes nothing and leaves the mask and depth unchanged. It sets the next PC to `br_target` when every active thread is taken, and to `br_fallthru` when no active thread is taken.
- R6: When `depth_out` is greater than 1 and the top entry's next PC equals its join PC, `pc_valid` is 0 for that cycle. The entry is popped at the next edge, and any branch or issue event offered in that cycle is ignored. The bottom entry is never popped.
- R7: Taken bits of inactive threads have no effect. Each pushed mask is a subset of the parent mask, the two pushed masks are disjoint, and together they cover the parent mask.
- R8: A divergent branch when `depth_out + 2 > STACK_DEPTH` sets `overflow`. In that case the PC, mask and depth stay as they were. `overflow` stays at 1 until reset.
- R9: When a branch and an issue event arrive in the same cycle, the branch is applied and `iss_pc` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A resolved branch is offered this cycle |
| br_taken | input | NUM_THREADS | Per-thread taken bits |
| br_target | input | PC_W | PC of the taken path |
| br_fallthru | input | PC_W | PC of the not-taken path |
| br_join | input | PC_W | PC where the two paths rejoin |
| iss_valid | input | 1 | A non-branch instruction was issued |
| iss_pc | input | PC_W | PC that follows the issued instruction |
| pc_out | output | PC_W | Next PC of the top entry |
| mask_out | output | NUM_THREADS | Active-thread mask of the top entry |
| pc_valid | output | 1 | 0 while the top entry is being popped |
| depth_out | output | $clog2(STACK_DEPTH+1) | Number of entries on the stack |
| overflow | output | 1 | Sticky error flag for a split that did not fit |

## Verification
The bench builds the block with four threads, 16-bit PCs and a stack of four entries, keeping smaller-path-first ordering. Four threads are enough to reproduce the two-way split of a full mask into 1001 and 0110 and its rejoin. They also allow uneven splits that exercise the ordering rule in both directions. A four-entry stack puts the overflow case within reach at the second nesting level, while the top entry still has two threads. With the default depth of six and four threads, smaller-first ordering leaves too few threads at the top to reach that case.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

  // What the stack does in a given cycle.
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_ISSUE,
    OP_UNIFORM,
    OP_DIVERGE,
    OP_OVERFLOW,
    OP_POP
  } stack_op_e;

  // Population count over a zero-extended mask of at most 64 threads.
  function automatic int unsigned mask_weight(input logic [63:0] m);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 64; k++) n += int'(m[k]);
    return n;
  endfunction

endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
  parameter int NUM_THREADS   = 4,
  parameter bit SMALLER_FIRST = 1'b1
) (
  input  logic [NUM_THREADS-1:0] parent_mask,
  input  logic [NUM_THREADS-1:0] taken_raw,
  output logic [NUM_THREADS-1:0] taken_mask,
  output logic [NUM_THREADS-1:0] fall_mask,
  output logic                   all_taken,
  output logic                   none_taken,
  output logic                   taken_on_top
);
  import simt_stack_pkg::*;

  int unsigned w_taken, w_fall;

  always_comb begin
    // Taken bits of masked-off threads are discarded here.
    taken_mask = taken_raw & parent_mask;
    fall_mask  = parent_mask & ~taken_raw;
    all_taken  = (fall_mask == '0);
    none_taken = (taken_mask == '0);
    w_taken    = mask_weight(64'(taken_mask));
    w_fall     = mask_weight(64'(fall_mask));
    if (SMALLER_FIRST) taken_on_top = (w_taken <= w_fall);
    else               taken_on_top = 1'b1;
  end

endmodule

// File: rtl/simt_entry_file.sv
module simt_entry_file #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 16,
  parameter int STACK_DEPTH = 6,
  parameter logic [PC_W-1:0] RESET_PC = 16'h0100,
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PTR_W-1:0]       top_idx,
  input  logic                   wr_top_en,
  input  logic [PC_W-1:0]        wr_top_pc,
  input  logic                   push_en,
  input  logic [PC_W-1:0]        push_join,
  input  logic [PC_W-1:0]        lo_next,
  input  logic [NUM_THREADS-1:0] lo_mask,
  input  logic [PC_W-1:0]        hi_next,
  input  logic [NUM_THREADS-1:0] hi_mask,
  output logic [PC_W-1:0]        top_next,
  output logic [PC_W-1:0]        top_join,
  output logic [NUM_THREADS-1:0] top_mask
);

  logic [PC_W-1:0]        next_q [STACK_DEPTH];
  logic [PC_W-1:0]        join_q [STACK_DEPTH];
  logic [NUM_THREADS-1:0] mask_q [STACK_DEPTH];

  logic [STACK_DEPTH-1:0] sel_top, sel_lo, sel_hi;

  // Per-slot write selects.
  for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_sel
    assign sel_top[i] = wr_top_en && (int'(top_idx) == i);
    assign sel_lo[i]  = push_en   && (int'(top_idx) + 1 == i);
    assign sel_hi[i]  = push_en   && (int'(top_idx) + 2 == i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STACK_DEPTH; i++) begin
        next_q[i] <= '0;
        join_q[i] <= '0;
        mask_q[i] <= '0;
      end
      next_q[0] <= RESET_PC;
      join_q[0] <= '1;
      mask_q[0] <= '1;
    end else begin
      for (int i = 0; i < STACK_DEPTH; i++) begin
        if (sel_top[i]) next_q[i] <= wr_top_pc;
        if (sel_lo[i]) begin
          next_q[i] <= lo_next;
          join_q[i] <= push_join;
          mask_q[i] <= lo_mask;
        end
        if (sel_hi[i]) begin
          next_q[i] <= hi_next;
          join_q[i] <= push_join;
          mask_q[i] <= hi_mask;
        end
      end
    end
  end

  assign top_next = next_q[top_idx];
  assign top_join = join_q[top_idx];
  assign top_mask = mask_q[top_idx];

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int NUM_THREADS   = 4,
  parameter int PC_W          = 16,
  parameter int STACK_DEPTH   = 6,
  parameter bit SMALLER_FIRST = 1'b1,
  parameter logic [PC_W-1:0] RESET_PC = 16'h0100,
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   br_valid,
  input  logic [NUM_THREADS-1:0] br_taken,
  input  logic [PC_W-1:0]        br_target,
  input  logic [PC_W-1:0]        br_fallthru,
  input  logic [PC_W-1:0]        br_join,
  input  logic                   iss_valid,
  input  logic [PC_W-1:0]        iss_pc,
  output logic [PC_W-1:0]        pc_out,
  output logic [NUM_THREADS-1:0] mask_out,
  output logic                   pc_valid,
  output logic [CNT_W-1:0]       depth_out,
  output logic                   overflow
);
  import simt_stack_pkg::*;

  logic [CNT_W-1:0]       depth_q;
  logic                   ovf_q;
  logic [PTR_W-1:0]       top_idx;
  logic [PC_W-1:0]        top_next, top_join;
  logic [NUM_THREADS-1:0] top_mask;

  // Named events for the checks.
  logic                   at_join;
  logic                   has_room;
  stack_op_e              op;

  logic [NUM_THREADS-1:0] taken_mask, fall_mask;
  logic                   all_taken, none_taken, taken_on_top;

  logic                   wr_top_en, push_en;
  logic [PC_W-1:0]        wr_top_pc, lo_next, hi_next;
  logic [NUM_THREADS-1:0] lo_mask, hi_mask;

  assign top_idx  = PTR_W'(depth_q - 1'b1);
  assign at_join  = (depth_q > CNT_W'(1)) && (top_next == top_join);
  assign has_room = (int'(depth_q) + 2 <= STACK_DEPTH);

  simt_branch_split #(
    .NUM_THREADS   (NUM_THREADS),
    .SMALLER_FIRST (SMALLER_FIRST)
  ) u_split (
    .parent_mask  (top_mask),
    .taken_raw    (br_taken),
    .taken_mask   (taken_mask),
    .fall_mask    (fall_mask),
    .all_taken    (all_taken),
    .none_taken   (none_taken),
    .taken_on_top (taken_on_top)
  );

  always_comb begin
    if (at_join)                        op = OP_POP;
    else if (br_valid) begin
      if (all_taken || none_taken)      op = OP_UNIFORM;
      else if (has_room)                op = OP_DIVERGE;
      else                              op = OP_OVERFLOW;
    end
    else if (iss_valid)                 op = OP_ISSUE;
    else                                op = OP_HOLD;
  end

  always_comb begin
    wr_top_en = (op == OP_ISSUE) || (op == OP_UNIFORM) || (op == OP_DIVERGE);
    push_en   = (op == OP_DIVERGE);
    unique case (op)
      OP_DIVERGE: wr_top_pc = br_join;
      OP_UNIFORM: wr_top_pc = all_taken ? br_target : br_fallthru;
      default:    wr_top_pc = iss_pc;
    endcase
    if (taken_on_top) begin
      lo_next = br_fallthru; lo_mask = fall_mask;
      hi_next = br_target;   hi_mask = taken_mask;
    end else begin
      lo_next = br_target;   lo_mask = taken_mask;
      hi_next = br_fallthru; hi_mask = fall_mask;
    end
  end

  simt_entry_file #(
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .STACK_DEPTH (STACK_DEPTH),
    .RESET_PC    (RESET_PC)
  ) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .top_idx   (top_idx),
    .wr_top_en (wr_top_en),
    .wr_top_pc (wr_top_pc),
    .push_en   (push_en),
    .push_join (br_join),
    .lo_next   (lo_next),
    .lo_mask   (lo_mask),
    .hi_next   (hi_next),
    .hi_mask   (hi_mask),
    .top_next  (top_next),
    .top_join  (top_join),
    .top_mask  (top_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= CNT_W'(1);
      ovf_q   <= 1'b0;
    end else begin
      if (op == OP_POP)      depth_q <= depth_q - 1'b1;
      if (op == OP_DIVERGE)  depth_q <= depth_q + CNT_W'(2);
      if (op == OP_OVERFLOW) ovf_q   <= 1'b1;
    end
  end

  assign pc_out    = top_next;
  assign mask_out  = top_mask;
  assign pc_valid  = !at_join;
  assign depth_out = depth_q;
  assign overflow  = ovf_q;

  // R1
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q >= CNT_W'(1) && int'(depth_q) <= STACK_DEPTH);

  // R2
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_out != '0);

  // R3
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DIVERGE |=> depth_q == $past(depth_q) + CNT_W'(2));

  // R4
  small_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIVERGE && SMALLER_FIRST) |=>
      2 * $countones(mask_out) <= $countones($past(mask_out)));

  // R5
  uniform_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_UNIFORM |=> $stable(depth_q) && $stable(mask_out));

  // R6
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_join |=> depth_q == $past(depth_q) - 1'b1);

  // R7
  split_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DIVERGE |->
      ((lo_mask | hi_mask) == mask_out) && ((lo_mask & hi_mask) == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_OVERFLOW |=> $stable(depth_q) && $stable(pc_out) && $stable(mask_out));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;

  localparam int NT = 4;
  localparam int PW = 16;
  localparam int SD = 4;
  localparam int CW = $clog2(SD + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_valid = 1'b0;
  logic [NT-1:0] br_taken = '0;
  logic [PW-1:0] br_target = '0, br_fallthru = '0, br_join = '0;
  logic          iss_valid = 1'b0;
  logic [PW-1:0] iss_pc = '0;
  logic [PW-1:0] pc_out;
  logic [NT-1:0] mask_out;
  logic          pc_valid;
  logic [CW-1:0] depth_out;
  logic          overflow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference model state: one queue per field, back is top of stack.
  logic [PW-1:0] m_next[$];
  logic [PW-1:0] m_join[$];
  logic [NT-1:0] m_mask[$];
  bit            m_ovf;

  always #2 clk = ~clk;

  simt_reconv_stack #(
    .NUM_THREADS   (NT),
    .PC_W          (PW),
    .STACK_DEPTH   (SD),
    .SMALLER_FIRST (1'b1),
    .RESET_PC      (16'h0100)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .br_valid (br_valid), .br_taken (br_taken), .br_target (br_target),
    .br_fallthru (br_fallthru), .br_join (br_join),
    .iss_valid (iss_valid), .iss_pc (iss_pc),
    .pc_out (pc_out), .mask_out (mask_out), .pc_valid (pc_valid),
    .depth_out (depth_out), .overflow (overflow)
  );

  function automatic int ones(input logic [NT-1:0] v);
    int c = 0;
    for (int k = 0; k < NT; k++) if (v[k]) c++;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_at_join();
    int n = m_next.size();
    return (n > 1) && (m_next[n-1] == m_join[n-1]);
  endfunction

  task automatic model_reset();
    m_next.delete(); m_join.delete(); m_mask.delete();
    m_next.push_back(16'h0100); m_join.push_back(16'hFFFF); m_mask.push_back('1);
    m_ovf = 1'b0;
  endtask

  task automatic model_step(input bit bv, input logic [NT-1:0] tk, input logic [PW-1:0] tg,
                            input logic [PW-1:0] ft, input logic [PW-1:0] jn,
                            input bit iv, input logic [PW-1:0] ip);
    int t = m_next.size() - 1;
    logic [NT-1:0] on, off;
    if (m_at_join()) begin
      void'(m_next.pop_back()); void'(m_join.pop_back()); void'(m_mask.pop_back());
    end else if (bv) begin
      on  = tk & m_mask[t];
      off = m_mask[t] & ~tk;
      if (on == '0) m_next[t] = ft;
      else if (off == '0) m_next[t] = tg;
      else if (m_next.size() + 2 > SD) m_ovf = 1'b1;
      else begin
        m_next[t] = jn;
        if (ones(on) <= ones(off)) begin
          m_next.push_back(ft); m_join.push_back(jn); m_mask.push_back(off);
          m_next.push_back(tg); m_join.push_back(jn); m_mask.push_back(on);
        end else begin
          m_next.push_back(tg); m_join.push_back(jn); m_mask.push_back(on);
          m_next.push_back(ft); m_join.push_back(jn); m_mask.push_back(off);
        end
      end
    end else if (iv) begin
      m_next[t] = ip;
    end
  endtask

  task automatic compare_all();
    int t = m_next.size() - 1;
    chk("R2 pc", 32'(pc_out), 32'(m_next[t]));
    chk("R2 mask", 32'(mask_out), 32'(m_mask[t]));
    chk("R6 valid", 32'(pc_valid), 32'(!m_at_join()));
    chk("R3 depth", 32'(depth_out), 32'(m_next.size()));
    chk("R8 overflow", 32'(overflow), 32'(m_ovf));
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic cyc(input bit bv, input logic [NT-1:0] tk, input logic [PW-1:0] tg,
                     input logic [PW-1:0] ft, input logic [PW-1:0] jn,
                     input bit iv, input logic [PW-1:0] ip);
    br_valid = bv; br_taken = tk; br_target = tg; br_fallthru = ft; br_join = jn;
    iss_valid = iv; iss_pc = ip;
    model_step(bv, tk, tg, ft, jn, iv, ip);
    @(negedge clk);
    br_valid = 1'b0; iss_valid = 1'b0;
    compare_all();
  endtask

  task automatic issue(input logic [PW-1:0] ip);
    cyc(1'b0, '0, '0, '0, '0, 1'b1, ip);
  endtask

  task automatic branch(input logic [NT-1:0] tk, input logic [PW-1:0] tg,
                        input logic [PW-1:0] ft, input logic [PW-1:0] jn);
    cyc(1'b1, tk, tg, ft, jn, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", 32'(pc_out), 32'h0100);
    chk("R1 mask", 32'(mask_out), 32'hF);
    chk("R1 depth", 32'(depth_out), 32'd1);
    chk("R1 valid", 32'(pc_valid), 32'd1);
    chk("R1 overflow", 32'(overflow), 32'd0);
    compare_all();

    issue(16'h0104);
    chk("R2 issue pc", 32'(pc_out), 32'h0104);

    // 1111 splits into 1001 and 0110; equal weights put the taken side on top
    branch(4'b1001, 16'h0200, 16'h0110, 16'h0300);
    chk("R3 top pc", 32'(pc_out), 32'h0200);
    chk("R4 tie taken top", 32'(mask_out), 32'h9);
    chk("R3 depth", 32'(depth_out), 32'd3);
    issue(16'h0204);
    issue(16'h0300);
    chk("R6 bubble", 32'(pc_valid), 32'd0);
    // branch offered in the pop cycle is ignored
    branch(4'b0001, 16'h0EEE, 16'h0DDD, 16'h0CCC);
    chk("R6 ignored pc", 32'(pc_out), 32'h0110);
    chk("R6 ignored mask", 32'(mask_out), 32'h6);
    chk("R6 depth", 32'(depth_out), 32'd2);
    issue(16'h0300);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0);
    chk("R6 rejoin mask", 32'(mask_out), 32'hF);
    chk("R6 rejoin pc", 32'(pc_out), 32'h0300);

    // R5 uniform branches
    branch(4'b1111, 16'h0400, 16'h0304, 16'h0500);
    chk("R5 all taken", 32'(pc_out), 32'h0400);
    chk("R5 depth", 32'(depth_out), 32'd1);
    branch(4'b0000, 16'h0600, 16'h0404, 16'h0500);
    chk("R5 none taken", 32'(pc_out), 32'h0404);

    // R4 uneven: not-taken side has one thread and goes on top
    branch(4'b0111, 16'h0700, 16'h0408, 16'h0800);
    chk("R4 small top mask", 32'(mask_out), 32'h8);
    chk("R4 small top pc", 32'(pc_out), 32'h0408);
    issue(16'h0800);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0);
    chk("R6 next path", 32'(mask_out), 32'h7);

    // R7 bit 3 is inactive in 0111; its taken bit has no effect
    branch(4'b1101, 16'h0900, 16'h0704, 16'h0A00);
    chk("R7 top mask", 32'(mask_out), 32'h2);
    chk("R7 depth", 32'(depth_out), 32'd4);
    issue(16'h0A00);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0);
    chk("R7 lower mask", 32'(mask_out), 32'h5);

    // R8 depth 3 plus two exceeds four
    branch(4'b0100, 16'h0B00, 16'h0904, 16'h0C00);
    chk("R8 flag", 32'(overflow), 32'd1);
    chk("R8 pc kept", 32'(pc_out), 32'h0900);
    chk("R8 depth kept", 32'(depth_out), 32'd3);
    issue(16'h0A00);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0);
    chk("R8 sticky", 32'(overflow), 32'd1);

    // R9 branch and issue together: branch wins
    cyc(1'b1, 4'b0111, 16'h0800, 16'h0A04, 16'h0F00, 1'b1, 16'h0D00);
    chk("R9 branch wins", 32'(pc_out), 32'h0800);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0);
    chk("R6 base mask", 32'(mask_out), 32'hF);
    chk("R6 base depth", 32'(depth_out), 32'd1);
    issue(16'hFFFF);
    chk("R6 bottom kept", 32'(pc_valid), 32'd1);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0);
    chk("R6 bottom depth", 32'(depth_out), 32'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule